// File: doc/BRIEF.md
# Acquisition Instruction Sequencer

This block walks a short program of acquisition instructions, up to eight, held in an external instruction memory. For each step it fetches one instruction word, decodes it and then carries it out. An instruction can do one of three things. It can run a single conversion at 8-bit or 12-bit-plus-sign resolution. It can run a pair of limit comparisons (watchdog mode), first against limit one and then against limit two. Or it can stall on a 16-bit countdown timer. The converter and the comparator sit outside the block. The block drives them with one-cycle start strobes, a limit select, channel codes and a resolution flag, and it waits for their done pulses.

Software controls the block through a start bit and a soft-reset pulse. After a soft reset the block fetches and decodes instruction 0 and then parks until start is set. An instruction can end the program early, so that execution wraps back to instruction 0. An instruction can also request a pause before it runs. The first pass through instruction 0 ignores that request. An instruction can also gate its conversion on an external sync pin. That pin is synchronised on the way in, and only its rising edges count.

Top module: `acq_seq`

## Requirements
- R1: A soft-reset pulse clears the start bit, sets the fetch address to 0 and parks the block with instruction 0 decoded. No strobe appears until start is set. With start set, the first instruction executed is instruction 0.
- R2: Instruction bits 4:2 drive `chan_pos_o` and bits 7:5 drive `chan_neg_o`, where code 000 means ground. Bit 10 drives `res8_o`, where 1 means 8-bit plus sign and 0 means 12-bit plus sign. These values are valid whenever a strobe is high.
- R3: Instructions run in increasing address order. After an instruction with bit 0 (end-of-program) set, the next instruction fetched is instruction 0.
- R4: When no instruction has bit 0 set, instruction 0 follows instruction 7.
- R5: When a fetched instruction has bit 1 (pause) set, the block halts before running it. In the same cycle it clears the start bit and pulses `int_pause_o` for one cycle. Setting start again runs that same instruction.
- R6: On the first execution of instruction 0 after a soft reset, its pause bit is ignored and no pause pulse occurs. On every later return to instruction 0, the pause bit takes effect.
- R7: An instruction with bit 9 (timer) set issues no strobe. It occupies reload+1 cycles, where reload is the value on `timer_reload_i` when the instruction starts.
- R8: An instruction with bit 11 (watchdog) set issues no conversion strobe. It issues two comparison strobes, the first with `cmp_sel_o`=0 and the second, after the first done, with `cmp_sel_o`=1.
- R9: When bit 8 (sync) is set and `sync_is_input_i` is 1, the block waits after acquisition for a rising edge on `sync_pin_i`. The strobe then appears on the third rising clock edge after the pin rises. In watchdog mode, each of the two comparisons waits for its own edge.
- R10: When `sync_is_input_i` is 0, bit 8 has no effect and the strobes follow acquisition without any edge.
- R11: When start is cleared during an instruction, that instruction completes and the block stops without fetching the next one. Setting start again resumes at the following instruction.
- R12: `int_limit_o` pulses for one cycle after each comparison done that reports a hit.
- R13: `busy_o` is 0 after reset, while parked and while stopped. It is 1 during every strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| soft_rst_i | input | 1 | Soft-reset pulse: rewind to instruction 0 and park |
| start_set_i | input | 1 | Pulse that sets the start bit |
| start_clr_i | input | 1 | Pulse that clears the start bit |
| sync_pin_i | input | 1 | Asynchronous external sync pin |
| sync_is_input_i | input | 1 | 1 when the sync pin is configured as an input |
| timer_reload_i | input | 16 | Countdown length for timer instructions |
| fetch_addr_o | output | 3 | Instruction memory address |
| fetch_data_i | input | 12 | Instruction word, one cycle after the address |
| conv_start_o | output | 1 | One-cycle conversion strobe |
| conv_done_i | input | 1 | Conversion finished |
| cmp_start_o | output | 1 | One-cycle comparison strobe |
| cmp_sel_o | output | 1 | Limit in use: 0 for the first, 1 for the second |
| cmp_done_i | input | 1 | Comparison finished |
| cmp_hit_i | input | 1 | Comparison result, valid with done |
| chan_pos_o | output | 3 | Non-inverting channel code |
| chan_neg_o | output | 3 | Inverting channel code, 000 = ground |
| res8_o | output | 1 | 1 = 8-bit plus sign, 0 = 12-bit plus sign |
| start_o | output | 1 | Current start bit |
| busy_o | output | 1 | Sequencer active |
| int_pause_o | output | 1 | Pause interrupt pulse |
| int_limit_o | output | 1 | Limit-hit interrupt pulse |

## Verification
The assertions take several things for granted about the surrounding system. Each done pulse arrives at least one cycle after its strobe, and there is exactly one done per strobe. `sync_is_input_i` holds steady while an instruction is waiting on the sync pin. The instruction memory changes only while the block is parked. The bench respects all of this. Its converter and comparator stubs answer a few cycles after each strobe. It rewrites the program and changes the sync configuration only after a pause, a stop or a soft reset. It raises the sync pin only while a sync wait is pending, and it lowers the pin again before the next edge is needed.

// File: rtl/acq_seq_pkg.sv
package acq_seq_pkg;

  // Instruction word; bit positions are decoded by the sequencer
  typedef struct packed {
    logic       watch;  // 11: two limit comparisons
    logic       res8;   // 10: 8-bit + sign resolution
    logic       timer;  //  9: countdown wait only
    logic       sync;   //  8: wait for sync edge
    logic [2:0] neg;    //  7:5 inverting channel
    logic [2:0] pos;    //  4:2 non-inverting channel
    logic       pause;  //  1: halt before running
    logic       last;   //  0: end of program
  } instr_t;

  typedef enum logic [3:0] {
    S_IDLE, S_FETCH, S_DECODE, S_HOLD, S_ACQ, S_TIMER,
    S_SYNCW, S_CONVW, S_CMPW, S_NEXT, S_STOP
  } seq_state_t;

endpackage

// File: rtl/acq_sync_edge.sv
module acq_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_i,
  output logic rise_o
);
  logic [STAGES-1:0] chain_q;
  logic              last_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain_q <= '0;
      last_q  <= 1'b0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], async_i};
      last_q  <= chain_q[STAGES-1];
    end
  end

  assign rise_o = chain_q[STAGES-1] & ~last_q;

  // R9
  rise_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    rise_o |=> !rise_o);

endmodule

// File: rtl/acq_countdown.sv
module acq_countdown #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load_i,
  input  logic [W-1:0] reload_i,
  output logic         zero_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)               cnt_q <= '0;
    else if (load_i)       cnt_q <= reload_i;
    else if (cnt_q != '0)  cnt_q <= cnt_q - W'(1);
  end

  assign zero_o = (cnt_q == '0);

  // R7
  no_count_up_chk: assert property (@(posedge clk) disable iff (rst)
    !load_i |=> cnt_q <= $past(cnt_q));

endmodule

// File: rtl/acq_seq.sv
module acq_seq
  import acq_seq_pkg::*;
#(
  parameter int N_INSTR     = 8,
  parameter int TMR_W       = 16,
  parameter int ACQ_CYCLES  = 4,
  parameter int SYNC_STAGES = 2,
  localparam int AW      = $clog2(N_INSTR),
  localparam int INSTR_W = $bits(instr_t)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               soft_rst_i,
  input  logic               start_set_i,
  input  logic               start_clr_i,
  input  logic               sync_pin_i,
  input  logic               sync_is_input_i,
  input  logic [TMR_W-1:0]   timer_reload_i,
  output logic [AW-1:0]      fetch_addr_o,
  input  logic [INSTR_W-1:0] fetch_data_i,
  output logic               conv_start_o,
  input  logic               conv_done_i,
  output logic               cmp_start_o,
  output logic               cmp_sel_o,
  input  logic               cmp_done_i,
  input  logic               cmp_hit_i,
  output logic [2:0]         chan_pos_o,
  output logic [2:0]         chan_neg_o,
  output logic               res8_o,
  output logic               start_o,
  output logic               busy_o,
  output logic               int_pause_o,
  output logic               int_limit_o
);
  localparam int ACQ_W = $clog2(ACQ_CYCLES + 1);

  seq_state_t       state_q;
  instr_t           ir_q;
  instr_t           cur_ir;
  logic [AW-1:0]    pc_q, nxt_pc, addr_q;
  logic [ACQ_W-1:0] acq_cnt_q;
  logic             first_q, start_q, sel_q;
  logic             conv_q, cmp_q, pint_q, lint_q;
  logic             pause_hit, go_exec, sync_gate, tmr_load, tmr_zero, sync_rise;

  acq_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .async_i(sync_pin_i), .rise_o(sync_rise));

  acq_countdown #(.W(TMR_W)) u_tmr (
    .clk(clk), .rst(rst), .load_i(tmr_load), .reload_i(timer_reload_i),
    .zero_o(tmr_zero));

  assign cur_ir    = (state_q == S_DECODE) ? instr_t'(fetch_data_i) : ir_q;
  assign pause_hit = cur_ir.pause && !(pc_q == '0 && first_q);
  assign go_exec   = !soft_rst_i && start_q &&
                     ((state_q == S_DECODE && !pause_hit) || state_q == S_HOLD);
  assign tmr_load  = go_exec && cur_ir.timer;
  assign sync_gate = ir_q.sync && sync_is_input_i;
  assign nxt_pc    = (ir_q.last || pc_q == AW'(N_INSTR - 1)) ? '0 : pc_q + AW'(1);

  // start bit: clears win over set
  always_ff @(posedge clk) begin
    if (rst)
      start_q <= 1'b0;
    else if (soft_rst_i || start_clr_i ||
             (state_q == S_DECODE && start_q && pause_hit))
      start_q <= 1'b0;
    else if (start_set_i)
      start_q <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= S_IDLE;
      ir_q      <= '0;
      pc_q      <= '0;
      addr_q    <= '0;
      acq_cnt_q <= '0;
      first_q   <= 1'b1;
      sel_q     <= 1'b0;
      conv_q    <= 1'b0;
      cmp_q     <= 1'b0;
      pint_q    <= 1'b0;
      lint_q    <= 1'b0;
    end else begin
      conv_q <= 1'b0;
      cmp_q  <= 1'b0;
      pint_q <= 1'b0;
      lint_q <= 1'b0;
      if (soft_rst_i) begin
        state_q <= S_FETCH;
        pc_q    <= '0;
        addr_q  <= '0;
        first_q <= 1'b1;
        sel_q   <= 1'b0;
      end else begin
        if (go_exec) begin
          if (pc_q == '0) first_q <= 1'b0;
          sel_q <= 1'b0;
          if (cur_ir.timer) state_q <= S_TIMER;
          else begin
            acq_cnt_q <= ACQ_W'(ACQ_CYCLES - 1);
            state_q   <= S_ACQ;
          end
        end
        unique case (state_q)
          S_FETCH: state_q <= S_DECODE;
          S_DECODE: begin
            ir_q <= cur_ir;
            if (!go_exec) begin
              state_q <= S_HOLD;
              if (start_q && pause_hit) pint_q <= 1'b1;
            end
          end
          S_ACQ: begin
            if (acq_cnt_q != '0) acq_cnt_q <= acq_cnt_q - ACQ_W'(1);
            else if (sync_gate) state_q <= S_SYNCW;
            else if (ir_q.watch) begin cmp_q <= 1'b1;  state_q <= S_CMPW;  end
            else                 begin conv_q <= 1'b1; state_q <= S_CONVW; end
          end
          S_SYNCW: if (sync_rise) begin
            if (ir_q.watch) begin cmp_q <= 1'b1;  state_q <= S_CMPW;  end
            else            begin conv_q <= 1'b1; state_q <= S_CONVW; end
          end
          S_CMPW: if (cmp_done_i) begin
            lint_q <= cmp_hit_i;
            if (!sel_q) begin
              sel_q <= 1'b1;
              if (sync_gate) state_q <= S_SYNCW;
              else           cmp_q   <= 1'b1;
            end else state_q <= S_NEXT;
          end
          S_CONVW: if (conv_done_i) state_q <= S_NEXT;
          S_TIMER: if (tmr_zero) state_q <= S_NEXT;
          S_NEXT: begin
            pc_q <= nxt_pc;
            if (start_q) begin addr_q <= nxt_pc; state_q <= S_FETCH; end
            else state_q <= S_STOP;
          end
          S_STOP: if (start_q) begin addr_q <= pc_q; state_q <= S_FETCH; end
          default: ;
        endcase
      end
    end
  end

  assign fetch_addr_o = addr_q;
  assign conv_start_o = conv_q;
  assign cmp_start_o  = cmp_q;
  assign cmp_sel_o    = sel_q;
  assign chan_pos_o   = ir_q.pos;
  assign chan_neg_o   = ir_q.neg;
  assign res8_o       = ir_q.res8;
  assign start_o      = start_q;
  assign int_pause_o  = pint_q;
  assign int_limit_o  = lint_q;
  assign busy_o       = !(state_q inside {S_IDLE, S_HOLD, S_STOP});

  // R8
  strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(conv_start_o && cmp_start_o));
  // R5
  pause_clears_start_chk: assert property (@(posedge clk) disable iff (rst)
    int_pause_o |-> !start_o);
  // R1
  soft_rst_chk: assert property (@(posedge clk) disable iff (rst)
    soft_rst_i |=> (!start_o && !conv_start_o && !cmp_start_o && fetch_addr_o == '0));
  // R13
  strobe_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (conv_start_o || cmp_start_o) |-> busy_o);
  // R2
  chan_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == S_CONVW && !soft_rst_i) |=> ($stable(chan_pos_o) && $stable(chan_neg_o)));
  // R10
  sync_cfg_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == S_SYNCW) |-> sync_is_input_i);

endmodule

// File: tb/acq_seq_bench.sv
module acq_seq_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        soft_rst = 0, start_set = 0, start_clr = 0;
  logic        sync_pin = 0, sync_is_input = 0;
  logic [15:0] reload = 16'd5;
  logic [2:0]  fetch_addr;
  logic [11:0] fetch_data;
  logic        conv_start, conv_done, cmp_start, cmp_sel, cmp_done, cmp_hit;
  logic [2:0]  chan_pos, chan_neg;
  logic        res8, start_bit, busy, int_pause, int_limit;

  logic [11:0] prog [8];
  int exp_q[$];
  int n_checks = 0, n_err = 0;
  int conv_cnt = 0, cmp_cnt = 0;
  int conv_wait = 0, cmp_wait = 0;
  int cyc = 0;

  always #2.5 clk = ~clk;

  acq_seq u_acq_seq (
    .clk(clk), .rst(rst), .soft_rst_i(soft_rst), .start_set_i(start_set),
    .start_clr_i(start_clr), .sync_pin_i(sync_pin), .sync_is_input_i(sync_is_input),
    .timer_reload_i(reload), .fetch_addr_o(fetch_addr), .fetch_data_i(fetch_data),
    .conv_start_o(conv_start), .conv_done_i(conv_done), .cmp_start_o(cmp_start),
    .cmp_sel_o(cmp_sel), .cmp_done_i(cmp_done), .cmp_hit_i(cmp_hit),
    .chan_pos_o(chan_pos), .chan_neg_o(chan_neg), .res8_o(res8), .start_o(start_bit),
    .busy_o(busy), .int_pause_o(int_pause), .int_limit_o(int_limit));

  // instruction memory and converter / comparator stubs
  always_ff @(posedge clk) fetch_data <= prog[fetch_addr];

  always_ff @(posedge clk) begin
    conv_done <= 1'b0;
    cmp_done  <= 1'b0;
    if (conv_start) conv_wait <= 3;
    else if (conv_wait > 0) begin
      conv_wait <= conv_wait - 1;
      if (conv_wait == 1) conv_done <= 1'b1;
    end
    if (cmp_start) cmp_wait <= 3;
    else if (cmp_wait > 0) begin
      cmp_wait <= cmp_wait - 1;
      if (cmp_wait == 1) begin cmp_done <= 1'b1; cmp_hit <= cmp_sel; end
    end
  end

  task automatic check(string req, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic check_evt(string req, int act);
    n_checks++;
    if (exp_q.size() == 0) begin
      n_err++;
      $display("FAIL %s: actual event %0d expected none", req, act);
    end else begin
      int e = exp_q.pop_front();
      if (e != act) begin
        n_err++;
        $display("FAIL %s: actual event %0d expected %0d", req, act, e);
      end
    end
  endtask

  // reference event stream, compared every clock
  always @(negedge clk) if (!rst) begin
    if (int_limit) check_evt("R12", 4000);
    if (conv_start) begin
      conv_cnt++;
      check_evt("R2", 1000 + res8 * 100 + chan_pos * 10 + chan_neg);
    end
    if (cmp_start) begin
      cmp_cnt++;
      check_evt("R8", 2000 + cmp_sel * 100 + chan_pos * 10 + chan_neg);
    end
    if (int_pause) check_evt("R5", 3000);
  end

  function automatic logic [11:0] mk(bit watch, bit r8, bit tmr, bit syn,
                                     int neg, int pos, bit pau, bit last);
    logic [2:0] n3 = neg[2:0];
    logic [2:0] p3 = pos[2:0];
    return {watch, r8, tmr, syn, n3, p3, pau, last};
  endfunction

  task automatic expect_instr(int i);
    int chan = prog[i][4:2] * 10 + prog[i][7:5];
    if (prog[i][9]) return;
    if (prog[i][11]) begin
      exp_q.push_back(2000 + chan);
      exp_q.push_back(2100 + chan);
      exp_q.push_back(4000);
    end else exp_q.push_back(1000 + prog[i][10] * 100 + chan);
  endtask

  task automatic pulse_soft();
    @(negedge clk) soft_rst = 1; @(negedge clk) soft_rst = 0;
    repeat (5) @(negedge clk);
  endtask
  task automatic pulse_start();
    @(negedge clk) start_set = 1; @(negedge clk) start_set = 0;
  endtask
  task automatic pulse_clr();
    start_clr = 1; @(negedge clk) start_clr = 0;
  endtask
  task automatic wait_empty(string req);
    int n = 0;
    while (exp_q.size() != 0 && n < 3000) begin @(negedge clk); n++; end
    check(req, exp_q.size(), 0);
  endtask
  task automatic sync_edge();
    @(negedge clk) sync_pin = 1;
    @(posedge clk); @(posedge clk);
    @(negedge clk) check("R9", cmp_start, 0);
    @(posedge clk);
    @(negedge clk) check("R9", cmp_start, 1);
    sync_pin = 0;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_err++;
      n_checks++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
      $finish;
    end
  end

  initial begin
    int c0, c1, c2;
    for (int i = 0; i < 8; i++) prog[i] = '0;
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R13 / R1: reset state
    check("R13", busy, 0);
    check("R1", start_bit, 0);
    check("R1", fetch_addr, 0);

    // program with end-of-program at 4, pause on 0
    prog[0] = mk(0, 0, 0, 0, 0, 3, 1, 0);
    prog[1] = mk(0, 1, 0, 0, 2, 5, 0, 0);
    prog[2] = mk(1, 0, 0, 0, 4, 1, 0, 0);
    prog[3] = mk(0, 0, 1, 0, 0, 0, 0, 0);
    prog[4] = mk(0, 0, 0, 0, 7, 7, 0, 1);
    pulse_soft();
    check("R1", busy, 0);
    check("R1", start_bit, 0);
    check("R1", fetch_addr, 0);
    check("R1", conv_cnt + cmp_cnt, 0);
    for (int i = 0; i < 5; i++) expect_instr(i);
    exp_q.push_back(3000);
    c0 = conv_cnt;
    pulse_start();
    wait_empty("R3");
    check("R5", start_bit, 0);
    check("R6", conv_cnt - c0, 3);
    @(negedge clk) check("R5", busy, 0);
    repeat (20) @(negedge clk);
    // resume instruction 0, then clear start during instruction 1
    expect_instr(0);
    expect_instr(1);
    pulse_start();
    wait_empty("R5");
    pulse_clr();
    repeat (40) @(negedge clk);
    check("R11", busy, 0);
    check("R11", start_bit, 0);
    // restart continues with instruction 2 and runs to the pause on 0
    for (int i = 2; i < 5; i++) expect_instr(i);
    exp_q.push_back(3000);
    pulse_start();
    wait_empty("R11");

    // eight instructions, no end-of-program bit
    for (int i = 0; i < 8; i++) prog[i] = mk(0, i % 2, 0, 0, 7 - i, i, i == 0, 0);
    pulse_soft();
    for (int i = 0; i < 8; i++) expect_instr(i);
    exp_q.push_back(3000);
    pulse_start();
    wait_empty("R4");
    check("R4", start_bit, 0);
    expect_instr(0);
    pulse_start();
    wait_empty("R5");
    pulse_clr();
    repeat (30) @(negedge clk);
    check("R11", busy, 0);

    // timer duration
    prog[0] = mk(0, 0, 1, 0, 0, 0, 0, 0);
    prog[1] = mk(0, 0, 0, 0, 0, 2, 0, 1);
    for (int k = 0; k < 2; k++) begin
      reload = (k == 0) ? 16'd10 : 16'd50;
      pulse_soft();
      expect_instr(1);
      @(negedge clk) start_set = 1;
      @(negedge clk) start_set = 0;
      c0 = 1;
      while (!conv_start && c0 < 1000) begin @(negedge clk); c0++; end
      pulse_clr();
      if (k == 0) c1 = c0; else c2 = c0;
      repeat (30) @(negedge clk);
    end
    check("R7", c2 - c1, 40);
    check("R7", (c1 >= 11) ? 1 : 0, 1);

    // sync-gated watchdog
    prog[0] = mk(1, 0, 0, 1, 1, 6, 0, 1);
    sync_is_input = 1;
    pulse_soft();
    expect_instr(0);
    c0 = cmp_cnt;
    pulse_start();
    repeat (30) @(negedge clk);
    check("R9", cmp_cnt - c0, 0);
    sync_edge();
    repeat (30) @(negedge clk);
    check("R9", cmp_cnt - c0, 1);
    sync_edge();
    pulse_clr();
    wait_empty("R12");
    repeat (20) @(negedge clk);
    check("R9", busy, 0);

    // sync bit without the pin configured as input
    sync_is_input = 0;
    pulse_soft();
    expect_instr(0);
    c0 = cmp_cnt;
    pulse_start();
    c1 = 0;
    while (cmp_cnt == c0 && c1 < 500) begin @(negedge clk); c1++; end
    pulse_clr();
    wait_empty("R10");
    repeat (20) @(negedge clk);
    check("R10", cmp_cnt - c0, 2);
    check("R13", busy, 0);

    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end
endmodule